// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a slower memory that is one word wide. It breaks each 32-bit byte address into a tag, a line index and a byte offset. For every line it keeps a tag and a valid bit, and it compares the stored tag with the address tag to decide whether the access hits. A load that hits returns its word one cycle after it is accepted. A load that misses stalls the processor while the whole line is read from memory, one word at a time and in ascending order. The new line replaces whatever line held that index before.

Stores are write-through. Each accepted store enters a small posted write buffer, which drains toward memory over a valid/ready handshake. A store that hits also updates the cached word. A store that misses leaves the cache as it was. The processor only waits on a store when the buffer is full. Before a refill issues any read, the buffer is drained completely, so memory always holds the newest data when the line is fetched.

Top module: `dm_wt_cache`

## Requirements
- R1: Address split: tag = addr[31:10], line index = addr[9:4], word within line = addr[3:2], and addr[1:0] are ignored. This is (addr / 16) mod 64, so byte addresses 0x4B0 (1200) and 0x8B0 both map to line 11 and evict each other.
- R2: Reset clears every valid bit. After reset, the first access to any address reports cpu_hit low. cpu_rvalid, mem_rd_valid and mem_wr_valid are low out of reset.
- R3: cpu_hit is high exactly when cpu_req is high, the indexed line is valid and its stored tag equals the address tag.
- R4: A load that hits is accepted in the cycle it is presented (cpu_ready high). cpu_rvalid is high in the following cycle, and cpu_rdata then carries the word selected by addr[3:2].
- R5: A load that misses holds cpu_ready low while the line is refilled. The refill issues four reads, one outstanding at a time, at line base +0x0, +0x4, +0x8 and +0xC in that order. The line is then marked valid with the new tag, and the load completes as a hit.
- R6: A store that hits updates the cached word and is also posted to memory. A later load of that address returns the stored data.
- R7: A store that misses does not allocate a line: a later load of the same address still reports cpu_hit low.
- R8: A store is accepted in the cycle it is presented while fewer than 4 writes are pending. With 4 pending, cpu_ready stays low for a store until an entry drains.
- R9: Pending writes leave in the order they were accepted, one per cycle in which mem_wr_valid and mem_wr_ready are both high, with word-aligned addresses.
- R10: No refill read (mem_rd_valid) is issued while any write is pending.
- R11: cpu_ready is low for as long as a refill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request accepted at this edge when high with cpu_req |
| cpu_hit | output | 1 | Presented address hits a valid line |
| cpu_rvalid | output | 1 | Load data valid (one cycle after accept) |
| cpu_rdata | output | 32 | Load data |
| mem_rd_valid | output | 1 | Refill word read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Refill word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned read word |
| mem_wr_valid | output | 1 | Buffered write available |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Write address (word aligned) |
| mem_wr_data | output | 32 | Write data |

## Verification
The assertions check on every cycle the rules that do not depend on the data. No refill read goes out while writes are pending. The processor is never ready during a refill, and a load miss is never accepted. An accepted load always returns data on the next cycle. A held read request keeps a stable address. The write buffer is never pushed when full or popped when empty. Only the bench scenarios can show the data-dependent behaviour: that two addresses sharing line 11 evict each other, that refill addresses come out in ascending order, that a store hit is visible to a later load, that a store miss leaves the line unallocated, that writes drain in FIFO order, and that reset really forgets the cached lines.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [1:0] {
      RF_IDLE  = 2'd0,
      RF_DRAIN = 2'd1,
      RF_REQ   = 2'd2,
      RF_WAIT  = 2'd3
   } rf_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
   parameter int DEPTH   = 4,
   parameter int ENTRY_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] push_data,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head_data,
   output logic               full,
   output logic               empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;

   logic [ENTRY_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]   wr_q, rd_q, wr_nx, rd_nx;
   logic [CNT_W-1:0]   cnt_q;

   if (dmc_pkg::is_pow2(DEPTH)) begin : g_wrap_free
      assign wr_nx = wr_q + 1'b1;
      assign rd_nx = rd_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nx = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nx = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) slot_q[wr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_nx;
         if (pop)  rd_q <= rd_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_data = slot_q[rd_q];
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign empty     = (cnt_q == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R9

endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
   parameter int TAG_W  = 22,
   parameter int IDX_W  = 6,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IDX_W-1:0]         lk_idx,
   input  logic [$clog2(WORDS)-1:0] lk_woff,
   output logic                     lk_valid,
   output logic [TAG_W-1:0]         lk_tag,
   output logic [WORD_W-1:0]        lk_word,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [$clog2(WORDS)-1:0] wr_woff,
   input  logic [WORD_W-1:0]        wr_data,
   input  logic                     inv_en,
   input  logic [IDX_W-1:0]         inv_idx,
   input  logic                     fill_en,
   input  logic [IDX_W-1:0]         fill_idx,
   input  logic [TAG_W-1:0]         fill_tag
);
   localparam int LINES  = 1 << IDX_W;
   localparam int WOFF_W = $clog2(WORDS);

   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [WORD_W-1:0] lane_rd [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         if (inv_en)  valid_q[inv_idx]  <= 1'b0;
         if (fill_en) valid_q[fill_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_idx] <= fill_tag;
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_lane
      logic [WORD_W-1:0] lane_q [LINES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_woff == WOFF_W'(w))) lane_q[wr_idx] <= wr_data;
      end
      assign lane_rd[w] = lane_q[lk_idx];
   end

   assign lk_valid = valid_q[lk_idx];
   assign lk_tag   = tag_q[lk_idx];
   assign lk_word  = lane_rd[lk_woff];

endmodule

// File: rtl/dmc_refill.sv
module dmc_refill #(
   parameter int TAG_W  = 22,
   parameter int IDX_W  = 6,
   parameter int WOFF_W = 2,
   parameter int BOFF_W = 2,
   parameter int WORD_W = 32,
   localparam int ADDR_W = TAG_W + IDX_W + WOFF_W + BOFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TAG_W-1:0]  start_tag,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic              wb_empty,
   output logic              busy,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   output logic              inv_en,
   output logic              fill_we,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [WOFF_W-1:0] fill_woff,
   output logic [WORD_W-1:0] fill_data,
   output logic              fill_done,
   output logic [TAG_W-1:0]  fill_tag
);
   import dmc_pkg::*;

   localparam logic [WOFF_W-1:0] LAST = WOFF_W'((1 << WOFF_W) - 1);

   rf_state_e         state_q;
   logic [TAG_W-1:0]  tag_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WOFF_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RF_IDLE;
         tag_q   <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            RF_IDLE: if (start) begin
               tag_q   <= start_tag;
               idx_q   <= start_idx;
               cnt_q   <= '0;
               state_q <= RF_DRAIN;
            end
            RF_DRAIN: if (wb_empty) state_q <= RF_REQ;
            RF_REQ:   if (rd_ready) state_q <= RF_WAIT;
            RF_WAIT:  if (rsp_valid) begin
               if (cnt_q == LAST) begin
                  state_q <= RF_IDLE;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
                  state_q <= RF_REQ;
               end
            end
            default: state_q <= RF_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != RF_IDLE);
   assign inv_en    = (state_q == RF_DRAIN) && wb_empty;
   assign rd_valid  = (state_q == RF_REQ);
   assign rd_addr   = {tag_q, idx_q, cnt_q, {BOFF_W{1'b0}}};
   assign fill_we   = (state_q == RF_WAIT) && rsp_valid;
   assign fill_done = fill_we && (cnt_q == LAST);
   assign fill_idx  = idx_q;
   assign fill_woff = cnt_q;
   assign fill_data = rsp_data;
   assign fill_tag  = tag_q;

   AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R5

endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int NUM_LINES  = 64,
   parameter int WBUF_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic              cpu_rvalid,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [WORD_W-1:0] mem_wr_data
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int WORDS      = LINE_BYTES / WORD_BYTES;
   localparam int BOFF_W     = $clog2(WORD_BYTES);
   localparam int WOFF_W     = $clog2(WORDS);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int IDX_W      = $clog2(NUM_LINES);
   localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
   localparam int ENTRY_W    = ADDR_W + WORD_W;

   if (WORD_W % 8 != 0 || !dmc_pkg::is_pow2(WORD_BYTES)) begin : g_bad_word
      $error("WORD_W must be a power-of-two number of bytes");
   end
   if (!dmc_pkg::is_pow2(LINE_BYTES) || WORDS < 2) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least two words");
   end
   if (!dmc_pkg::is_pow2(NUM_LINES) || NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end
   if (WBUF_DEPTH < 2) begin : g_bad_wbuf
      $error("WBUF_DEPTH must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too narrow for the index and offset fields");
   end

   // address fields
   logic [TAG_W-1:0]  a_tag;
   logic [IDX_W-1:0]  a_idx;
   logic [WOFF_W-1:0] a_woff;
   logic [BOFF_W-1:0] unused_boff;

   assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_idx       = cpu_addr[OFF_W +: IDX_W];
   assign a_woff      = cpu_addr[BOFF_W +: WOFF_W];
   assign unused_boff = cpu_addr[BOFF_W-1:0];

   // lookup
   logic              lk_valid, lk_hit;
   logic [TAG_W-1:0]  lk_tag;
   logic [WORD_W-1:0] lk_word;

   // refill side
   logic              busy, rf_start, inv_en, fill_we, fill_done;
   logic [IDX_W-1:0]  fill_idx;
   logic [WOFF_W-1:0] fill_woff;
   logic [WORD_W-1:0] fill_data;
   logic [TAG_W-1:0]  fill_tag;

   // write buffer
   logic               wb_push, wb_pop, wb_full, wb_empty;
   logic [ENTRY_W-1:0] wb_head;

   // processor side
   logic              accept, st_hit_we;
   logic              ls_wr_en;
   logic [IDX_W-1:0]  ls_wr_idx;
   logic [WOFF_W-1:0] ls_wr_woff;
   logic [WORD_W-1:0] ls_wr_data;
   logic              rvalid_q;
   logic [WORD_W-1:0] rdata_q;

   assign lk_hit    = lk_valid && (lk_tag == a_tag);
   assign cpu_hit   = cpu_req && lk_hit;
   assign cpu_ready = !busy && (cpu_we ? !wb_full : lk_hit);
   assign accept    = cpu_req && cpu_ready;
   assign rf_start  = cpu_req && !cpu_we && !busy && !lk_hit;
   assign st_hit_we = accept && cpu_we && lk_hit;

   assign ls_wr_en   = st_hit_we || fill_we;
   assign ls_wr_idx  = busy ? fill_idx  : a_idx;
   assign ls_wr_woff = busy ? fill_woff : a_woff;
   assign ls_wr_data = busy ? fill_data : cpu_wdata;

   assign wb_push = accept && cpu_we;
   assign wb_pop  = mem_wr_valid && mem_wr_ready;

   assign mem_wr_valid = !wb_empty;
   assign mem_wr_addr  = wb_head[ENTRY_W-1 -: ADDR_W];
   assign mem_wr_data  = wb_head[WORD_W-1:0];

   dmc_line_store #(
      .TAG_W  (TAG_W),
      .IDX_W  (IDX_W),
      .WORD_W (WORD_W),
      .WORDS  (WORDS)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (a_idx),
      .lk_woff  (a_woff),
      .lk_valid (lk_valid),
      .lk_tag   (lk_tag),
      .lk_word  (lk_word),
      .wr_en    (ls_wr_en),
      .wr_idx   (ls_wr_idx),
      .wr_woff  (ls_wr_woff),
      .wr_data  (ls_wr_data),
      .inv_en   (inv_en),
      .inv_idx  (fill_idx),
      .fill_en  (fill_done),
      .fill_idx (fill_idx),
      .fill_tag (fill_tag)
   );

   dmc_refill #(
      .TAG_W  (TAG_W),
      .IDX_W  (IDX_W),
      .WOFF_W (WOFF_W),
      .BOFF_W (BOFF_W),
      .WORD_W (WORD_W)
   ) i_refill (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rf_start),
      .start_tag (a_tag),
      .start_idx (a_idx),
      .wb_empty  (wb_empty),
      .busy      (busy),
      .rd_valid  (mem_rd_valid),
      .rd_ready  (mem_rd_ready),
      .rd_addr   (mem_rd_addr),
      .rsp_valid (mem_rsp_valid),
      .rsp_data  (mem_rsp_data),
      .inv_en    (inv_en),
      .fill_we   (fill_we),
      .fill_idx  (fill_idx),
      .fill_woff (fill_woff),
      .fill_data (fill_data),
      .fill_done (fill_done),
      .fill_tag  (fill_tag)
   );

   dmc_wbuf #(
      .DEPTH   (WBUF_DEPTH),
      .ENTRY_W (ENTRY_W)
   ) i_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wb_push),
      .push_data ({cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}, cpu_wdata}),
      .pop       (wb_pop),
      .head_data (wb_head),
      .full      (wb_full),
      .empty     (wb_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= accept && !cpu_we;
         if (accept && !cpu_we) rdata_q <= lk_word;
      end
   end

   assign cpu_rvalid = rvalid_q;
   assign cpu_rdata  = rdata_q;

   AST_LOAD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cpu_we) |=> cpu_rvalid); // R4
   AST_STALL_IN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cpu_ready); // R11
   AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> wb_empty); // R10
   AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && !cpu_hit) |-> !cpu_ready); // R5

endmodule

// File: tb/test_dm_wt_cache.sv
module test_dm_wt_cache;

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic        exp_hit;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_04B0, 32'h0,          1'b0}, // R1 R2 1200 -> line 11, cold miss
      '{1'b0, 32'h0000_04B4, 32'h0,          1'b1}, // R4 word 1
      '{1'b0, 32'h0000_04BC, 32'h0,          1'b1}, // R4 word 3
      '{1'b0, 32'h0000_08B0, 32'h0,          1'b0}, // R1 same line, other tag
      '{1'b0, 32'h0000_04B0, 32'h0,          1'b0}, // R1 evicted
      '{1'b1, 32'h0000_04B8, 32'hDEAD_BEEF,  1'b1}, // R6 store hit
      '{1'b0, 32'h0000_04B8, 32'h0,          1'b1}, // R6 load sees it
      '{1'b1, 32'h0000_1000, 32'h1234_5678,  1'b0}, // R7 store miss
      '{1'b0, 32'h0000_1000, 32'h0,          1'b0}, // R7 not allocated
      '{1'b0, 32'h0000_0010, 32'h0,          1'b0}, // R5 line 1
      '{1'b0, 32'h0000_0016, 32'h0,          1'b1}, // R1 low bits ignored
      '{1'b1, 32'h0000_0014, 32'hA1B2_C3D4,  1'b1}, // R6
      '{1'b0, 32'h0000_0014, 32'h0,          1'b1}  // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_ready, cpu_hit, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        mem_rd_valid, mem_wr_valid;
   logic        mem_rd_ready = 1'b1;
   logic        mem_wr_ready = 1'b1;
   logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int errors = 0;
   int checks = 0;
   logic [31:0] mem_aa [logic [31:0]];
   logic [31:0] ref_aa [logic [31:0]];
   logic [31:0] rd_log [64];
   logic [31:0] wr_log [64];
   int rd_n = 0;
   int wr_n = 0;

   always #5 clk = ~clk;

   dm_wt_cache i_dm_wt_cache (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .cpu_ready     (cpu_ready),
      .cpu_hit       (cpu_hit),
      .cpu_rvalid    (cpu_rvalid),
      .cpu_rdata     (cpu_rdata),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .mem_wr_valid  (mem_wr_valid),
      .mem_wr_ready  (mem_wr_ready),
      .mem_wr_addr   (mem_wr_addr),
      .mem_wr_data   (mem_wr_data)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {~a[15:0], a[15:0]} ^ 32'h5A00_00A5;
   endfunction

   function automatic logic [31:0] expect_word(input logic [31:0] a);
      logic [31:0] wa;
      wa = {a[31:2], 2'b00};
      return ref_aa.exists(wa) ? ref_aa[wa] : pat(wa);
   endfunction

   // next-level memory model
   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem_aa.exists(mem_rd_addr) ? mem_aa[mem_rd_addr] : pat(mem_rd_addr);
         if (rd_n < 64) rd_log[rd_n] = mem_rd_addr;
         rd_n = rd_n + 1;
      end
      if (mem_wr_valid && mem_wr_ready) begin
         mem_aa[mem_wr_addr] = mem_wr_data;
         if (wr_n < 64) wr_log[wr_n] = mem_wr_addr;
         wr_n = wr_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input bit we, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!cpu_ready && n < 500) begin
         @(negedge clk);
         #1;
         n++;
      end
   endtask

   task automatic finish_req(output logic rv, output logic [31:0] rd);
      @(negedge clk);
      #1;
      rv = cpu_rvalid;
      rd = cpu_rdata;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic wait_drained();
      for (int k = 0; k < 100 && mem_wr_valid; k++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic        h, rv;
      logic [31:0] rd;
      int          n, base;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R2 reset state
      chk(!cpu_rvalid,   "R2 rvalid", 32'(cpu_rvalid), 0);
      chk(!mem_rd_valid, "R2 rd_valid", 32'(mem_rd_valid), 0);
      chk(!mem_wr_valid, "R2 wr_valid", 32'(mem_wr_valid), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].we, VECS[i].addr, VECS[i].wdata);
         h = cpu_hit;
         chk(h == VECS[i].exp_hit, "R3 hit", 32'(h), 32'(VECS[i].exp_hit));
         wait_ready(n);
         if (VECS[i].we) begin
            chk(n == 0, "R8 store accepted at once", n, 0);
            ref_aa[{VECS[i].addr[31:2], 2'b00}] = VECS[i].wdata;
            finish_req(rv, rd);
         end else begin
            if (VECS[i].exp_hit) chk(n == 0, "R4 hit no wait", n, 0);
            else                 chk(n >= 8 && n < 500, "R11 refill stall", n, 8);
            finish_req(rv, rd);
            chk(rv == 1'b1, "R4 rvalid", 32'(rv), 1);
            chk(rd == expect_word(VECS[i].addr), "R4 data", rd, expect_word(VECS[i].addr));
         end
      end

      // R5 refill order of the first two misses
      for (int k = 0; k < 4; k++)
         chk(rd_log[k] == 32'h4B0 + 32'(4 * k), "R5 refill order", rd_log[k], 32'h4B0 + 32'(4 * k));
      chk(rd_log[4] == 32'h8B0, "R1 line 11 refill base", rd_log[4], 32'h8B0);

      // R8 / R9: fill the write buffer while memory refuses writes
      wait_drained();
      mem_wr_ready = 1'b0;
      base = wr_n;
      for (int k = 0; k < 4; k++) begin
         drive(1'b1, 32'h2000 + 32'(k * 8) + 32'd3, 32'hC000_0000 + 32'(k));
         wait_ready(n);
         chk(n == 0, "R8 buffer not full", n, 0);
         ref_aa[32'h2000 + 32'(k * 8)] = 32'hC000_0000 + 32'(k);
         finish_req(rv, rd);
      end
      drive(1'b1, 32'h2040, 32'hC000_0004);
      chk(!cpu_ready, "R8 full stalls store", 32'(cpu_ready), 0);
      repeat (3) @(negedge clk);
      #1;
      chk(!cpu_ready, "R8 still stalled", 32'(cpu_ready), 0);
      mem_wr_ready = 1'b1;
      wait_ready(n);
      chk(n < 500, "R8 resumes after drain", n, 1);
      ref_aa[32'h2040] = 32'hC000_0004;
      finish_req(rv, rd);
      wait_drained();
      for (int k = 0; k < 4; k++)
         chk(wr_log[base + k] == 32'h2000 + 32'(k * 8), "R9 drain order",
             wr_log[base + k], 32'h2000 + 32'(k * 8));
      chk(wr_log[base + 4] == 32'h2040, "R9 last entry", wr_log[base + 4], 32'h2040);

      // R10: refill waits for pending writes
      mem_wr_ready = 1'b0;
      drive(1'b1, 32'h5000, 32'h0BAD_F00D);
      ref_aa[32'h5000] = 32'h0BAD_F00D;
      finish_req(rv, rd);
      drive(1'b0, 32'h5000, 32'h0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         #1;
         chk(!mem_rd_valid, "R10 no read while pending", 32'(mem_rd_valid), 0);
      end
      chk(!cpu_ready, "R11 stalled during drain", 32'(cpu_ready), 0);
      mem_wr_ready = 1'b1;
      wait_ready(n);
      finish_req(rv, rd);
      chk(rd == 32'h0BAD_F00D, "R10 fresh data", rd, 32'h0BAD_F00D);

      // R2: reset forgets cached lines
      wait_drained();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 32'h0000_04B8, 32'h0);
      chk(!cpu_hit, "R2 miss after reset", 32'(cpu_hit), 0);
      wait_ready(n);
      finish_req(rv, rd);
      chk(rd == 32'hDEAD_BEEF, "R6 written through", rd, 32'hDEAD_BEEF);

      repeat (2) @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule